// File: doc/BRIEF.md
# Shared-Bus Port Transmit Controller

This block sits in one port of a switch whose line modules share a single wide data bus under a central arbiter. Complete frames handed to it are queued as 256-bit beats. The port raises a request, and once the arbiter grants the bus it streams a frame onto the data bus at one beat per clock. Frames that have crossed the bus sit at a central lookup engine until a verdict comes back on a separate result bus. The port lets a bounded number of its own frames await verdicts at once, so bus time is not lost while lookups are in flight.

Fairness between ports with different frame sizes comes from a byte budget, not from a per-frame limit. Every beat the port places on the bus adds to a running byte count. A new frame may begin only while that count is below a configured threshold. A frame already under way always runs to its end. When the port can start nothing more it withdraws its request. The count returns to zero once the grant is gone.

The same port also listens to the bus and keeps a copy of every frame seen there. Verdicts arrive in bus order. Each one releases the oldest held copy, either onto the egress stream (forward) or into nothing (drop).

Top module: `sbus_port_tx`

## Requirements
- R1: `bus_req` is high only while a complete frame is queued, fewer than 31 own frames await verdicts, and the byte count is below `cfg_byte_thresh` (or a frame is mid-transfer). `dbus_valid` is never high without `bus_gnt`.
- R2: Frames go onto the data bus in queue order, one 256-bit beat per clock, with no idle cycle between the beats of one frame. `dbus_last` marks the final beat.
- R3: With 31 own frames awaiting verdicts, no new frame starts and the request stays low. Transmission resumes after a verdict for an own frame arrives.
- R4: The count of own frames awaiting verdicts rises when a frame's last beat is sent. It falls only on a result message with `rbus_self` = 1. A result with `rbus_self` = 0 leaves it unchanged.
- R5: Each beat sent adds 32 bytes to the byte count. A frame may start only while the count is below `cfg_byte_thresh`. A frame that crosses the threshold part-way is still sent to its last beat, and then the request drops.
- R6: The byte count returns to zero on any clock edge at which `bus_gnt` is low. After the grant is released, a port with frames still queued requests again and continues.
- R7: Every frame seen on the snoop input is held. Result messages apply in first-in first-out order to the held frames. `rbus_fwd` = 1 (forward) sends the frame's beats, in order, out on the egress stream, with `egress_last` on the final beat.
- R8: `rbus_fwd` = 0 (drop) discards the held frame with no egress beat, and later frames are unaffected.
- R9: After reset, `bus_req`, `dbus_valid` and `egress_valid` are low and `tx_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit beat offered |
| tx_in_data | input | 256 | Transmit beat data |
| tx_in_last | input | 1 | Final beat of the offered frame |
| tx_in_ready | output | 1 | Transmit queue can take a beat |
| cfg_byte_thresh | input | 16 | Byte budget threshold |
| bus_req | output | 1 | Request to the central arbiter |
| bus_gnt | input | 1 | Grant from the central arbiter |
| dbus_valid | output | 1 | Port drives a beat on the data bus |
| dbus_data | output | 256 | Data bus beat |
| dbus_last | output | 1 | Final beat of the frame on the bus |
| snoop_valid | input | 1 | Beat observed on the data bus |
| snoop_data | input | 256 | Observed beat data |
| snoop_last | input | 1 | Observed final beat |
| rbus_valid | input | 1 | Result message present |
| rbus_self | input | 1 | Result belongs to a frame this port sent |
| rbus_fwd | input | 1 | 1 = forward, 0 = drop |
| egress_valid | output | 1 | Forwarded beat to the egress port |
| egress_data | output | 256 | Forwarded beat data |
| egress_last | output | 1 | Final forwarded beat of a frame |

## Verification
The assertions rely on four properties of the block's inputs. The arbiter keeps the grant asserted for as long as a frame is mid-transfer. A result message never arrives before the last beat of the frame it judges has been seen on the snoop input. A result with `rbus_self` set never arrives while no own frame is outstanding. The snoop stream never overruns the held-copy storage. The bench's arbiter model grants one cycle after a request and holds the grant until the request falls. The bench sends each result only after the frames it covers have been logged on the bus. Its frame counts stay well inside the held-copy depth.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   typedef enum logic {
      VERD_DROP = 1'b0,
      VERD_FWD  = 1'b1
   } verdict_e;

   function automatic int unsigned bytes_per_beat(input int unsigned data_w);
      return data_w / 8;
   endfunction
endpackage

// File: rtl/sbus_fifo.sv
module sbus_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_p, wr_p, rd_nx, wr_nx;
   logic [CW-1:0] cnt;
   logic          wr_en, rd_en;

   generate
      if (DEPTH < 2) begin : g_chk_depth
         $error("sbus_fifo: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nx = wr_p + 1'b1;
         assign rd_nx = rd_p + 1'b1;
      end else begin : g_wrap
         assign wr_nx = (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
         assign rd_nx = (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      end
   endgenerate

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign wr_en = push && !full;
   assign rd_en = pop && !empty;
   assign dout  = mem[rd_p];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_p] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else begin
         if (wr_en) wr_p <= wr_nx;
         if (rd_en) rd_p <= rd_nx;
         cnt <= cnt + CW'(wr_en) - CW'(rd_en);
      end
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R2
endmodule

// File: rtl/sbus_tx_ctrl.sv
module sbus_tx_ctrl #(
   parameter int MAX_OUT    = 31,
   parameter int BEAT_BYTES = 32,
   parameter int BCW        = 16,
   parameter int TX_DEPTH   = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           enq_last,
   input  logic           head_last,
   input  logic           bus_gnt,
   input  logic [BCW-1:0] cfg_thresh,
   input  logic           res_self,
   output logic           bus_req,
   output logic           beat_go
);
   localparam int OW = $clog2(MAX_OUT + 1);
   localparam int QW = $clog2(TX_DEPTH + 1);

   logic           in_frame;
   logic [OW-1:0]  outst;
   logic [QW-1:0]  frames_q;
   logic [BCW-1:0] byte_cnt;
   logic [BCW:0]   byte_sum;
   logic           can_start, frame_end;

   generate
      if (MAX_OUT < 1) begin : g_chk_out
         $error("sbus_tx_ctrl: MAX_OUT must be at least 1");
      end
      if (BEAT_BYTES >= (1 << BCW)) begin : g_chk_bcw
         $error("sbus_tx_ctrl: BCW too narrow for one beat");
      end
   endgenerate

   assign can_start = (frames_q != '0) && (outst < OW'(MAX_OUT)) && (byte_cnt < cfg_thresh);
   assign bus_req   = in_frame || can_start;
   assign beat_go   = bus_gnt && (in_frame || can_start);
   assign frame_end = beat_go && head_last;
   assign byte_sum  = {1'b0, byte_cnt} + (BCW+1)'(BEAT_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         outst    <= '0;
         frames_q <= '0;
         byte_cnt <= '0;
      end else begin
         if (beat_go) in_frame <= !head_last;
         outst    <= outst + OW'(frame_end) - OW'(res_self);
         frames_q <= frames_q + QW'(enq_last) - QW'(frame_end);
         if (!bus_gnt)
            byte_cnt <= '0;
         else if (beat_go)
            byte_cnt <= byte_sum[BCW] ? '1 : byte_sum[BCW-1:0];
      end
   end

   AST_DRIVE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n) beat_go |-> bus_gnt);  // R1
   AST_GNT_HELD:        assert property (@(posedge clk) disable iff (!rst_n) in_frame |-> bus_gnt);  // R2
   AST_NO_START_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                                         (outst == OW'(MAX_OUT) && !in_frame) |-> !beat_go);  // R3
   AST_SELF_RES_OWED:   assert property (@(posedge clk) disable iff (!rst_n) res_self |-> (outst != '0));  // R4
   AST_FRAME_FINISHES:  assert property (@(posedge clk) disable iff (!rst_n) in_frame |-> beat_go);  // R5
   AST_BUDGET_CLEAR:    assert property (@(posedge clk) disable iff (!rst_n) !bus_gnt |=> (byte_cnt == '0));  // R6
endmodule

// File: rtl/sbus_rx_drain.sv
module sbus_rx_drain
   import sbus_pkg::*;
#(
   parameter int DATA_W   = 256,
   parameter int RX_DEPTH = 64,
   parameter int VDEPTH   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snoop_valid,
   input  logic [DATA_W-1:0] snoop_data,
   input  logic              snoop_last,
   input  logic              res_valid,
   input  logic              res_fwd,
   output logic              egress_valid,
   output logic [DATA_W-1:0] egress_data,
   output logic              egress_last
);
   localparam int UW = $clog2(RX_DEPTH + 1);

   logic [DATA_W:0] rx_dout;
   logic            rx_empty, rx_full, rx_pop;
   logic            v_dout, v_empty, v_full, v_pop;
   logic            active;
   verdict_e        cur_verdict;
   logic [UW-1:0]   unmatched;

   sbus_fifo #(.W(DATA_W + 1), .DEPTH(RX_DEPTH)) u_copy (
      .clk(clk), .rst_n(rst_n),
      .push(snoop_valid), .din({snoop_last, snoop_data}),
      .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
   );

   sbus_fifo #(.W(1), .DEPTH(VDEPTH)) u_verd (
      .clk(clk), .rst_n(rst_n),
      .push(res_valid), .din(res_fwd),
      .pop(v_pop), .dout(v_dout), .empty(v_empty), .full(v_full)
   );

   assign v_pop        = !active && !v_empty;
   assign rx_pop       = active && !rx_empty;
   assign egress_valid = rx_pop && (cur_verdict == VERD_FWD);
   assign egress_data  = rx_dout[DATA_W-1:0];
   assign egress_last  = rx_dout[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active      <= 1'b0;
         cur_verdict <= VERD_DROP;
         unmatched   <= '0;
      end else begin
         if (v_pop) begin
            active      <= 1'b1;
            cur_verdict <= verdict_e'(v_dout);
         end else if (rx_pop && rx_dout[DATA_W]) begin
            active <= 1'b0;
         end
         unmatched <= unmatched + UW'(snoop_valid && snoop_last) - UW'(res_valid);
      end
   end

   AST_VERDICT_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> (unmatched != '0));  // R7
   AST_VERDICT_ROOM:      assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !v_full);  // R7
   AST_COPY_ROOM:         assert property (@(posedge clk) disable iff (!rst_n) snoop_valid |-> !rx_full);  // R7
   AST_DRAIN_CONTIG:      assert property (@(posedge clk) disable iff (!rst_n)
                                           (rx_pop && !rx_dout[DATA_W]) |=> rx_pop);  // R8
endmodule

// File: rtl/sbus_port_tx.sv
module sbus_port_tx #(
   parameter int DATA_W   = 256,
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 64,
   parameter int VDEPTH   = 32,
   parameter int MAX_OUT  = 31,
   parameter int BCW      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_in_valid,
   input  logic [DATA_W-1:0] tx_in_data,
   input  logic              tx_in_last,
   output logic              tx_in_ready,
   input  logic [BCW-1:0]    cfg_byte_thresh,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              dbus_valid,
   output logic [DATA_W-1:0] dbus_data,
   output logic              dbus_last,
   input  logic              snoop_valid,
   input  logic [DATA_W-1:0] snoop_data,
   input  logic              snoop_last,
   input  logic              rbus_valid,
   input  logic              rbus_self,
   input  logic              rbus_fwd,
   output logic              egress_valid,
   output logic [DATA_W-1:0] egress_data,
   output logic              egress_last
);
   localparam int BEAT_BYTES = sbus_pkg::bytes_per_beat(DATA_W);

   logic [DATA_W:0] tx_dout;
   logic            tx_empty, tx_full, beat_go, enq;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_chk_dw
         $error("sbus_port_tx: DATA_W must be a whole number of bytes");
      end
   endgenerate

   assign tx_in_ready = !tx_full;
   assign enq         = tx_in_valid && !tx_full;

   sbus_fifo #(.W(DATA_W + 1), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(enq), .din({tx_in_last, tx_in_data}),
      .pop(beat_go), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
   );

   sbus_tx_ctrl #(
      .MAX_OUT(MAX_OUT), .BEAT_BYTES(BEAT_BYTES), .BCW(BCW), .TX_DEPTH(TX_DEPTH)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .enq_last(enq && tx_in_last),
      .head_last(tx_dout[DATA_W]),
      .bus_gnt(bus_gnt),
      .cfg_thresh(cfg_byte_thresh),
      .res_self(rbus_valid && rbus_self),
      .bus_req(bus_req),
      .beat_go(beat_go)
   );

   assign dbus_valid = beat_go;
   assign dbus_data  = tx_dout[DATA_W-1:0];
   assign dbus_last  = tx_dout[DATA_W];

   sbus_rx_drain #(.DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH), .VDEPTH(VDEPTH)) u_drain (
      .clk(clk), .rst_n(rst_n),
      .snoop_valid(snoop_valid), .snoop_data(snoop_data), .snoop_last(snoop_last),
      .res_valid(rbus_valid), .res_fwd(rbus_fwd),
      .egress_valid(egress_valid), .egress_data(egress_data), .egress_last(egress_last)
   );

   AST_BEATS_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
                                            (dbus_valid && !dbus_last) |=> dbus_valid);  // R2
   AST_DRIVE_HAS_DATA:     assert property (@(posedge clk) disable iff (!rst_n) dbus_valid |-> !tx_empty);  // R1
   AST_REQ_WHILE_DRIVING:  assert property (@(posedge clk) disable iff (!rst_n) dbus_valid |-> bus_req);  // R1
endmodule

// File: tb/sim_sbus_port_tx.sv
module sim_sbus_port_tx;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_v = 1'b0, tx_l = 1'b0;
   logic [DW-1:0] tx_d = '0;
   logic          tx_rdy;
   logic [15:0]   thresh = 16'hFFFF;
   logic          req, gnt = 1'b0, hold_arb = 1'b0;
   logic          dv, dl;
   logic [DW-1:0] dd;
   logic          ext_v = 1'b0;
   logic [DW-1:0] ext_d = '0;
   logic          sv, sl;
   logic [DW-1:0] sd;
   logic          rv = 1'b0, rself = 1'b0, rfwd = 1'b0;
   logic          ev, el;
   logic [DW-1:0] ed;

   int checks = 0, fails = 0, gaps = 0;
   logic [DW-1:0] exp_bus[$], bus_log[$], exp_egr[$], egr_log[$];
   bit in_pkt = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) gnt <= !rst_n ? 1'b0 : (req && !hold_arb);

   assign sv = dv | ext_v;
   assign sd = dv ? dd : ext_d;
   assign sl = dv ? dl : ext_v;

   sbus_port_tx u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_in_valid(tx_v), .tx_in_data(tx_d), .tx_in_last(tx_l), .tx_in_ready(tx_rdy),
      .cfg_byte_thresh(thresh),
      .bus_req(req), .bus_gnt(gnt),
      .dbus_valid(dv), .dbus_data(dd), .dbus_last(dl),
      .snoop_valid(sv), .snoop_data(sd), .snoop_last(sl),
      .rbus_valid(rv), .rbus_self(rself), .rbus_fwd(rfwd),
      .egress_valid(ev), .egress_data(ed), .egress_last(el)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (dv) bus_log.push_back(dd);
         if (in_pkt && !dv) gaps++;
         if (dv) in_pkt = !dl;
         if (ev) egr_log.push_back(ed);
      end
   end

   function automatic logic [DW-1:0] mk(input int id, input int b);
      return {8{32'((id << 8) | b)}};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
      end
   endtask

   task automatic cmp_bus(input string rq);
      int bad = 0;
      chk(bus_log.size() == exp_bus.size(), rq, "bus beat count", bus_log.size(), exp_bus.size());
      foreach (bus_log[i]) if (i < exp_bus.size() && bus_log[i] !== exp_bus[i]) bad++;
      chk(bad == 0, rq, "bus beat mismatches", bad, 0);
   endtask

   task automatic cmp_egr(input string rq);
      int bad = 0;
      chk(egr_log.size() == exp_egr.size(), rq, "egress beat count", egr_log.size(), exp_egr.size());
      foreach (egr_log[i]) if (i < exp_egr.size() && egr_log[i] !== exp_egr[i]) bad++;
      chk(bad == 0, rq, "egress beat mismatches", bad, 0);
   endtask

   task automatic clear_logs();
      exp_bus.delete(); bus_log.delete(); exp_egr.delete(); egr_log.delete();
   endtask

   task automatic push_frame(input int id, input int n);
      for (int b = 0; b < n; b++) begin
         while (!tx_rdy) @(negedge clk);
         tx_v = 1'b1; tx_d = mk(id, b); tx_l = (b == n - 1);
         exp_bus.push_back(mk(id, b));
         @(negedge clk);
         tx_v = 1'b0; tx_l = 1'b0;
      end
   endtask

   task automatic send_result(input bit self_b, input bit fwd_b);
      @(negedge clk);
      rv = 1'b1; rself = self_b; rfwd = fwd_b;
      @(negedge clk);
      rv = 1'b0; rself = 1'b0; rfwd = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req == 1'b0, "R9", "bus_req in reset", req, 0);
      chk(dv == 1'b0, "R9", "dbus_valid in reset", dv, 0);
      chk(ev == 1'b0, "R9", "egress_valid in reset", ev, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_rdy == 1'b1, "R9", "tx_in_ready after reset", tx_rdy, 1);
   endtask

   task automatic t_basic();
      clear_logs(); thresh = 16'hFFFF;
      push_frame(1, 2);
      push_frame(2, 3);
      wait_cycles(20);
      cmp_bus("R2");
      chk(gaps == 0, "R2", "idle cycles inside a frame", gaps, 0);
      chk(req == 1'b0, "R1", "request with empty queue", req, 0);
      foreach (exp_bus[i]) exp_egr.push_back(exp_bus[i]);
      send_result(1'b1, 1'b1);
      send_result(1'b1, 1'b1);
      wait_cycles(20);
      cmp_egr("R7");
   endtask

   task automatic t_drop();
      clear_logs(); thresh = 16'hFFFF;
      push_frame(3, 1);
      push_frame(4, 2);
      push_frame(5, 1);
      wait_cycles(15);
      exp_egr.push_back(mk(3, 0));
      exp_egr.push_back(mk(5, 0));
      send_result(1'b1, 1'b1);
      send_result(1'b1, 1'b0);
      send_result(1'b1, 1'b1);
      wait_cycles(20);
      cmp_egr("R8");
   endtask

   task automatic t_budget();
      clear_logs();
      // part 1: one-beat frames, threshold 96 bytes -> three starts (0, 32, 64)
      thresh = 16'd96; hold_arb = 1'b1;
      for (int f = 0; f < 5; f++) push_frame(10 + f, 1);
      wait_cycles(3);
      chk(req == 1'b1 && dv == 1'b0, "R1", "no drive before grant", dv, 0);
      hold_arb = 1'b0;
      while (bus_log.size() < 3) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      chk(req == 1'b0 && dv == 1'b0, "R5", "request after budget used", req, 0);
      chk(bus_log.size() == 3, "R5", "beats in first burst", bus_log.size(), 3);
      wait_cycles(30);
      chk(bus_log.size() == 5, "R6", "beats after regrant", bus_log.size(), 5);
      // part 2: threshold 40 bytes, 3-beat frame crosses it mid-frame
      thresh = 16'd40; hold_arb = 1'b1;
      push_frame(20, 3);
      push_frame(21, 3);
      wait_cycles(2);
      hold_arb = 1'b0;
      while (bus_log.size() < 8) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      chk(req == 1'b0 && dv == 1'b0, "R5", "stop after finished frame", req, 0);
      chk(bus_log.size() == 8, "R5", "whole frame sent across threshold", bus_log.size(), 8);
      wait_cycles(30);
      cmp_bus("R6");
      for (int f = 0; f < 7; f++) send_result(1'b1, 1'b0);
      wait_cycles(20);
      cmp_egr("R8");
   endtask

   task automatic t_outstanding();
      clear_logs(); thresh = 16'hFFFF;
      @(negedge clk);
      ext_v = 1'b1; ext_d = mk(99, 0);
      @(negedge clk);
      ext_v = 1'b0;
      for (int f = 0; f < 32; f++) push_frame(30 + f, 1);
      wait_cycles(30);
      chk(bus_log.size() == 31, "R3", "frames sent at outstanding cap", bus_log.size(), 31);
      chk(req == 1'b0, "R3", "request at outstanding cap", req, 0);
      send_result(1'b0, 1'b0);
      wait_cycles(10);
      chk(bus_log.size() == 31, "R4", "foreign result releases nothing", bus_log.size(), 31);
      send_result(1'b1, 1'b0);
      wait_cycles(10);
      chk(bus_log.size() == 32, "R4", "own result frees a slot", bus_log.size(), 32);
      cmp_bus("R3");
      for (int f = 0; f < 31; f++) send_result(1'b1, 1'b0);
      wait_cycles(80);
      cmp_egr("R8");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_drop();
      t_budget();
      t_outstanding();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule